// File: doc/BRIEF.md
# Indirect Redirection Register Window

This block is the software-facing register front end of an interrupt redirection controller with 24 input pins. Software sees only two 32-bit words. The select word at offset 0x00 holds an 8-bit index. The window word at offset 0x10 reads or writes whichever 32-bit register that index names. Behind the window sit a version word, an identification word and a table of 64-bit redirection entries. Each entry takes two consecutive indices, one per half.

The block holds every entry and presents all of them on a flat bus for the delivery engine. The engine writes back the hardware-owned remote-IRR and delivery-status bits through a status-update port. Software writes leave those bits alone, with one exception: a write that leaves an entry edge-triggered clears remote-IRR. A change to a mask or trigger-mode bit raises a one-cycle notification that carries the pin.

Read data comes from a two-state response machine. In S_IDLE, rd_valid is low. A read accepted in either state moves it to S_RESP for the following cycle, and there rd_valid is high with the captured word on rd_data. S_RESP returns to S_IDLE unless a new read is accepted in the same cycle, in which case it stays in S_RESP. Any other cycle leaves the machine in S_IDLE.

Top module: `irq_redir_window`

## Requirements
- R1: A write to offset 0x00 stores data bits 7:0 in the select register. A read at offset 0x00 or 0x10 returns its word on rd_data, with rd_valid high, in the cycle after the read is presented.
- R2: With select 0x00, a window read returns NUM_PINS-1 in bits 23:16, the version code 0x11 in bits 7:0 and zero elsewhere. Window writes at this index change nothing.
- R3: A window write with select 0x01 stores data bits 27:24 as the ID. A window read with select 0x01 or 0x02 returns the ID in bits 27:24 and zero elsewhere. A window write with select 0x02 is ignored.
- R4: A table select addresses entry (select-0x10)>>1, taken modulo 256. An odd select reaches entry bits 63:32 and an even select reaches bits 31:0. The entry fields are: vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12, polarity 13, remote-IRR 14, trigger mode 15 (1 = level), mask 16, destination 63:56.
- R5: A window read whose table index is 24 or more returns 0xFFFFFFFF. This covers selects 0x03 to 0x0F and 0x40 to 0xFF. A window write to such an index changes no entry.
- R6: A window write to an entry keeps its delivery-status bit 12 and its remote-IRR bit 14, whatever the data holds. The only exception is the clear described in R7.
- R7: After any entry write that leaves bit 15 at 0 (edge), bit 14 of that entry is 0.
- R8: A low-half write that changes mask bit 16 raises mchg_valid for one cycle, the cycle after the write, with the pin and the new mask. A low-half write that changes bit 15 does the same on tchg_valid, tchg_pin and tchg_level.
- R9: An upd_valid with pin p loads upd_rirr into bit 14 and upd_dstat into bit 12 of entry p in the next cycle. If a software write hits the same entry in the same cycle, the update values take precedence over the preserved ones, and R7 is then applied.
- R10: After reset, every entry reads with only bit 16 set, the select register is 0 and the ID is 0.
- R11: An access at any offset other than 0x00 and 0x10 reads as 0 and its write changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 8 | Word offset within the block |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (cycle after read) |
| rd_data | output | 32 | Read data |
| upd_valid | input | 1 | Status update from the delivery engine |
| upd_pin | input | PIN_W (5) | Pin for the status update |
| upd_rirr | input | 1 | New remote-IRR value |
| upd_dstat | input | 1 | New delivery-status value |
| ent_bits | output | NUM_PINS*64 | All entries, entry i in bits i*64+63:i*64 |
| mchg_valid | output | 1 | Mask-change pulse |
| mchg_pin | output | PIN_W (5) | Pin whose mask changed |
| mchg_mask | output | 1 | New mask value |
| tchg_valid | output | 1 | Trigger-mode-change pulse |
| tchg_pin | output | PIN_W (5) | Pin whose trigger mode changed |
| tchg_level | output | 1 | New trigger mode (1 = level) |

## Verification
A software window write to an entry and a status update from the delivery engine can both land on the same entry in the same cycle. The bench provokes this in three ways: on a level entry, on an entry the write turns edge-triggered, and on two different pins at once. A bench model applies the update first and then the write rules, and each outcome is judged against it on the entry bus and by window reads. A read can also fall in the same cycle as a status update. That read must return the pre-update word, and the next read must show the update.

// File: rtl/irw_pkg.sv
package irw_pkg;
    localparam int ENTRY_W = 64;
    localparam logic [7:0] OFF_SEL  = 8'h00;
    localparam logic [7:0] OFF_WIN  = 8'h10;
    localparam logic [7:0] IDX_VER  = 8'h00;
    localparam logic [7:0] IDX_ID   = 8'h01;
    localparam logic [7:0] IDX_ARB  = 8'h02;
    localparam logic [7:0] TBL_BASE = 8'h10;
    localparam int B_DSTAT = 12;
    localparam int B_RIRR  = 14;
    localparam int B_TRIG  = 15;
    localparam int B_MASK  = 16;

    typedef enum logic {S_IDLE, S_RESP} resp_state_e;
endpackage

// File: rtl/irw_entry.sv
module irw_entry
    import irw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_hi,
    input  logic [31:0]        wr_data,
    input  logic               upd_en,
    input  logic               upd_rirr,
    input  logic               upd_dstat,
    output logic [ENTRY_W-1:0] entry,
    output logic               mask_flip,
    output logic               trig_flip
);
    logic [ENTRY_W-1:0] merged;
    logic [ENTRY_W-1:0] entry_d;
    logic               rirr_keep;
    logic               dstat_keep;

    always_comb begin
        rirr_keep  = upd_en ? upd_rirr  : entry[B_RIRR];
        dstat_keep = upd_en ? upd_dstat : entry[B_DSTAT];
        merged     = wr_hi ? {wr_data, entry[31:0]} : {entry[63:32], wr_data};
        merged[B_DSTAT] = dstat_keep;
        merged[B_RIRR]  = merged[B_TRIG] ? rirr_keep : 1'b0;
        entry_d = entry;
        if (wr_en) begin
            entry_d = merged;
        end else if (upd_en) begin
            entry_d[B_RIRR]  = upd_rirr;
            entry_d[B_DSTAT] = upd_dstat;
        end
    end

    assign mask_flip = wr_en && !wr_hi && (wr_data[B_MASK] != entry[B_MASK]);
    assign trig_flip = wr_en && !wr_hi && (wr_data[B_TRIG] != entry[B_TRIG]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) entry <= ENTRY_W'(1) << B_MASK;
        else        entry <= entry_d;
    end

    // R6
    status_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !upd_en) |=> (entry[B_DSTAT] == $past(entry[B_DSTAT]) &&
                                (!entry[B_TRIG] || entry[B_RIRR] == $past(entry[B_RIRR]))));
    // R7
    edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (entry[B_TRIG] || !entry[B_RIRR]));
    // R9
    upd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !wr_en) |=> (entry[B_RIRR] == $past(upd_rirr) &&
                                entry[B_DSTAT] == $past(upd_dstat)));
endmodule

// File: rtl/irw_front.sv
module irw_front
    import irw_pkg::*;
#(
    parameter int         NUM_PINS     = 24,
    parameter int         PIN_W        = 5,
    parameter logic [7:0] VERSION_CODE = 8'h11
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        acc_valid,
    input  logic                        acc_write,
    input  logic [7:0]                  acc_offset,
    input  logic [31:0]                 acc_wdata,
    input  logic [NUM_PINS*ENTRY_W-1:0] ent_bits,
    output logic                        rd_valid,
    output logic [31:0]                 rd_data,
    output logic                        tbl_wr,
    output logic                        tbl_hi,
    output logic [PIN_W-1:0]            tbl_idx
);
    localparam logic [7:0] TOP_PIN = 8'(NUM_PINS - 1);

    resp_state_e state_q, state_d;
    logic [7:0]  sel_q;
    logic [3:0]  id_q;
    logic [6:0]  idx7;
    logic        in_range;
    logic        rd_acc, wr_sel, wr_win;
    logic [31:0] tbl_word, win_word, rd_next, rd_q;

    assign rd_acc   = acc_valid && !acc_write;
    assign wr_sel   = acc_valid && acc_write && acc_offset == OFF_SEL;
    assign wr_win   = acc_valid && acc_write && acc_offset == OFF_WIN;
    assign idx7     = 7'((sel_q - TBL_BASE) >> 1);
    assign in_range = 32'(idx7) < NUM_PINS;
    assign tbl_idx  = idx7[PIN_W-1:0];
    assign tbl_hi   = sel_q[0];
    assign tbl_wr   = wr_win && in_range;

    always_comb begin
        tbl_word = '1;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (in_range && tbl_idx == PIN_W'(i))
                tbl_word = sel_q[0] ? ent_bits[i*ENTRY_W+32 +: 32] : ent_bits[i*ENTRY_W +: 32];
        end
        if (sel_q == IDX_VER)
            win_word = {8'h00, TOP_PIN, 8'h00, VERSION_CODE};
        else if (sel_q == IDX_ID || sel_q == IDX_ARB)
            win_word = {4'h0, id_q, 24'h0};
        else
            win_word = tbl_word;
        if (acc_offset == OFF_SEL)      rd_next = {24'h0, sel_q};
        else if (acc_offset == OFF_WIN) rd_next = win_word;
        else                            rd_next = '0;
    end

    // next-state logic
    always_comb begin
        unique case (state_q)
            S_IDLE:  state_d = rd_acc ? S_RESP : S_IDLE;
            S_RESP:  state_d = rd_acc ? S_RESP : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            id_q  <= '0;
            rd_q  <= '0;
        end else begin
            if (wr_sel) sel_q <= acc_wdata[7:0];
            if (wr_win && sel_q == IDX_ID) id_q <= acc_wdata[27:24];
            if (rd_acc) rd_q <= rd_next;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            S_RESP:  rd_valid = 1'b1;
            default: rd_valid = 1'b0;
        endcase
        rd_data = rd_q;
    end

    // R1
    sel_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel |=> (sel_q == $past(acc_wdata[7:0])));
    // R1
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_acc));
    // R3
    id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_win && sel_q == IDX_ID) |=> $stable(id_q));
endmodule

// File: rtl/irq_redir_window.sv
module irq_redir_window
    import irw_pkg::*;
#(
    parameter int         NUM_PINS     = 24,
    parameter logic [7:0] VERSION_CODE = 8'h11,
    localparam int        PIN_W        = $clog2(NUM_PINS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        acc_valid,
    input  logic                        acc_write,
    input  logic [7:0]                  acc_offset,
    input  logic [31:0]                 acc_wdata,
    output logic                        rd_valid,
    output logic [31:0]                 rd_data,
    input  logic                        upd_valid,
    input  logic [PIN_W-1:0]            upd_pin,
    input  logic                        upd_rirr,
    input  logic                        upd_dstat,
    output logic [NUM_PINS*ENTRY_W-1:0] ent_bits,
    output logic                        mchg_valid,
    output logic [PIN_W-1:0]            mchg_pin,
    output logic                        mchg_mask,
    output logic                        tchg_valid,
    output logic [PIN_W-1:0]            tchg_pin,
    output logic                        tchg_level
);
    logic               tbl_wr, tbl_hi;
    logic [PIN_W-1:0]   tbl_idx;
    logic [NUM_PINS-1:0] mflip, tflip, mask_vec;
    logic [PIN_W-1:0]   flip_pin;

    irw_front #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W), .VERSION_CODE(VERSION_CODE)) u_front (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_offset(acc_offset), .acc_wdata(acc_wdata),
        .ent_bits(ent_bits),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .tbl_wr(tbl_wr), .tbl_hi(tbl_hi), .tbl_idx(tbl_idx)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
        irw_entry u_ent (
            .clk(clk), .rst_n(rst_n),
            .wr_en(tbl_wr && tbl_idx == PIN_W'(i)),
            .wr_hi(tbl_hi), .wr_data(acc_wdata),
            .upd_en(upd_valid && upd_pin == PIN_W'(i)),
            .upd_rirr(upd_rirr), .upd_dstat(upd_dstat),
            .entry(ent_bits[i*ENTRY_W +: ENTRY_W]),
            .mask_flip(mflip[i]), .trig_flip(tflip[i])
        );
        assign mask_vec[i] = ent_bits[i*ENTRY_W + B_MASK];
    end

    always_comb begin
        flip_pin = '0;
        for (int i = 0; i < NUM_PINS; i++)
            if (mflip[i] || tflip[i]) flip_pin = PIN_W'(i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mchg_valid <= 1'b0;
            mchg_pin   <= '0;
            mchg_mask  <= 1'b0;
            tchg_valid <= 1'b0;
            tchg_pin   <= '0;
            tchg_level <= 1'b0;
        end else begin
            mchg_valid <= |mflip;
            tchg_valid <= |tflip;
            if (|mflip) begin
                mchg_pin  <= flip_pin;
                mchg_mask <= acc_wdata[B_MASK];
            end
            if (|tflip) begin
                tchg_pin   <= flip_pin;
                tchg_level <= acc_wdata[B_TRIG];
            end
        end
    end

    // R8
    mask_note_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mchg_valid |-> (32'(mchg_pin) < NUM_PINS && mask_vec[mchg_pin] == mchg_mask));
    // R8
    mask_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mchg_valid |-> $past(acc_valid && acc_write));
endmodule

// File: tb/tb_irq_redir_window.sv
`timescale 1ns/1ps
module tb_irq_redir_window;
    localparam int NP = 24;
    localparam int PW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0, acc_write = 1'b0;
    logic [7:0] acc_offset = '0;
    logic [31:0] acc_wdata = '0;
    logic rd_valid;
    logic [31:0] rd_data;
    logic upd_valid = 1'b0;
    logic [PW-1:0] upd_pin = '0;
    logic upd_rirr = 1'b0, upd_dstat = 1'b0;
    logic [NP*64-1:0] ent_bits;
    logic mchg_valid, mchg_mask, tchg_valid, tchg_level;
    logic [PW-1:0] mchg_pin, tchg_pin;

    irq_redir_window dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_offset(acc_offset), .acc_wdata(acc_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .upd_valid(upd_valid), .upd_pin(upd_pin),
        .upd_rirr(upd_rirr), .upd_dstat(upd_dstat), .ent_bits(ent_bits),
        .mchg_valid(mchg_valid), .mchg_pin(mchg_pin), .mchg_mask(mchg_mask),
        .tchg_valid(tchg_valid), .tchg_pin(tchg_pin), .tchg_level(tchg_level)
    );

    always #10 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [63:0] m_ent [NP];
    logic [7:0]  m_sel;
    logic [3:0]  m_id;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [7:0] off);
        int idx;
        if (off == 8'h00) return {24'h0, m_sel};
        if (off != 8'h10) return 32'h0;
        if (m_sel == 8'h00) return {8'h00, 8'(NP - 1), 8'h00, 8'h11};
        if (m_sel == 8'h01 || m_sel == 8'h02) return {4'h0, m_id, 24'h0};
        idx = int'(8'(m_sel - 8'h10)) / 2;
        if (idx >= NP) return 32'hFFFF_FFFF;
        return m_sel[0] ? m_ent[idx][63:32] : m_ent[idx][31:0];
    endfunction

    // one access (optionally with a status update), checked one cycle later
    task automatic acc(input bit wr, input logic [7:0] off, input logic [31:0] d,
                       input bit uv, input int up, input bit ur, input bit ud,
                       input string tag);
        logic [31:0] exp_rd;
        logic [63:0] old_e, new_e;
        bit e_m, e_t, e_mm, e_tl;
        int e_pin, idx;
        exp_rd = m_read(off);
        e_m = 0; e_t = 0; e_mm = 0; e_tl = 0; e_pin = 0;
        acc_valid = 1'b1; acc_write = wr; acc_offset = off; acc_wdata = d;
        upd_valid = uv; upd_pin = PW'(up); upd_rirr = ur; upd_dstat = ud;
        if (uv && up < NP) begin
            m_ent[up][14] = ur;
            m_ent[up][12] = ud;
        end
        if (wr && off == 8'h00) m_sel = d[7:0];
        else if (wr && off == 8'h10) begin
            if (m_sel == 8'h01) m_id = d[27:24];
            else if (m_sel > 8'h02) begin
                idx = int'(8'(m_sel - 8'h10)) / 2;
                if (idx < NP) begin
                    old_e = m_ent[idx];
                    new_e = m_sel[0] ? {d, old_e[31:0]} : {old_e[63:32], d};
                    new_e[12] = old_e[12];
                    new_e[14] = new_e[15] ? old_e[14] : 1'b0;
                    if (!m_sel[0]) begin
                        e_m = new_e[16] != old_e[16]; e_mm = new_e[16];
                        e_t = new_e[15] != old_e[15]; e_tl = new_e[15];
                    end
                    e_pin = idx;
                    m_ent[idx] = new_e;
                end
            end
        end
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; upd_valid = 1'b0;
        if (!wr) chk(rd_valid === 1'b1 && rd_data === exp_rd, {tag, " read"}, {31'h0, rd_valid, rd_data}, {32'h1, exp_rd});
        else begin
            chk(mchg_valid === e_m && (!e_m || (mchg_pin === PW'(e_pin) && mchg_mask === e_mm)),
                {tag, " R8 mask note"}, {mchg_valid, mchg_mask, 3'h0, mchg_pin}, {e_m, e_mm, 3'h0, PW'(e_pin)});
            chk(tchg_valid === e_t && (!e_t || (tchg_pin === PW'(e_pin) && tchg_level === e_tl)),
                {tag, " R8 trig note"}, {tchg_valid, tchg_level, 3'h0, tchg_pin}, {e_t, e_tl, 3'h0, PW'(e_pin)});
        end
        for (int p = 0; p < NP; p++)
            chk(ent_bits[p*64 +: 64] === m_ent[p], {tag, " entry bus"}, ent_bits[p*64 +: 64], m_ent[p]);
    endtask

    task automatic wr(input logic [7:0] off, input logic [31:0] d, input string tag);
        acc(1'b1, off, d, 1'b0, 0, 1'b0, 1'b0, tag);
    endtask
    task automatic rd(input logic [7:0] off, input string tag);
        acc(1'b0, off, 32'h0, 1'b0, 0, 1'b0, 1'b0, tag);
    endtask
    task automatic rd_sel(input logic [7:0] s, input string tag);
        wr(8'h00, {24'h0, s}, tag);
        rd(8'h10, tag);
    endtask

    function automatic logic [31:0] lo_word(input int p, input bit msk, input bit lvl);
        return {15'h0, msk, lvl, 1'b1, 1'b0, 1'b1, 1'b0, 3'(p), 8'(8'h20 + p)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < NP; p++) m_ent[p] = 64'h1_0000;
        m_sel = '0; m_id = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(rd_valid === 1'b0, "R10 rd_valid idle", {63'h0, rd_valid}, 64'h0);
        for (int p = 0; p < NP; p++)
            chk(ent_bits[p*64 +: 64] === 64'h1_0000, "R10 reset entry", ent_bits[p*64 +: 64], 64'h1_0000);
        rd(8'h00, "R10 select");
        rd(8'h10, "R2 version");
        rd_sel(8'h01, "R10 id");
        // R1 select register
        wr(8'h00, 32'h0000_00A5, "R1");
        rd(8'h00, "R1");
        wr(8'h00, 32'hFFFF_F1FF, "R1");
        rd(8'h00, "R1");
        // R2 version writes ignored
        wr(8'h00, 32'h0, "R2");
        wr(8'h10, 32'hFFFF_FFFF, "R2");
        rd(8'h10, "R2");
        // R3 id / arbitration
        rd_sel(8'h01, "R3");
        wr(8'h10, 32'hF7FF_FFFF, "R3");
        rd(8'h10, "R3");
        rd_sel(8'h02, "R3");
        wr(8'h10, 32'h3000_0000, "R3");
        rd_sel(8'h01, "R3");
        // R10 sweep of table at reset
        for (int s = 16; s < 16 + 2*NP; s++) rd_sel(8'(s), "R10 table");
        // R5 out-of-range reads and writes
        for (int s = 3; s < 16; s++) rd_sel(8'(s), "R5");
        for (int s = 16 + 2*NP; s < 256; s++) rd_sel(8'(s), "R5");
        wr(8'h00, 32'h40, "R5"); wr(8'h10, 32'h0, "R5");
        wr(8'h00, 32'h0F, "R5"); wr(8'h10, 32'h0, "R5");
        wr(8'h00, 32'hFF, "R5"); wr(8'h10, 32'h0, "R5");
        // R4 program every entry, both halves
        for (int p = 0; p < NP; p++) begin
            wr(8'h00, 32'(16 + 2*p), "R4");
            wr(8'h10, lo_word(p, 1'b0, p[0]), "R4 R6");
            wr(8'h00, 32'(17 + 2*p), "R4");
            wr(8'h10, {8'(p*7 + 1), 24'h00ABCD}, "R4");
        end
        for (int s = 16; s < 16 + 2*NP; s++) rd_sel(8'(s), "R4");
        // R9 status updates on level pins, with a read in the same cycle
        wr(8'h00, 32'h12, "R9");
        for (int p = 1; p < NP; p += 2)
            acc(1'b0, 8'h10, 32'h0, 1'b1, p, 1'b1, 1'b1, "R9");
        for (int p = 0; p < NP; p++) rd_sel(8'(16 + 2*p), "R9");
        // R6 rewrite of a level entry keeps status bits
        wr(8'h00, 32'h12, "R6");
        wr(8'h10, {15'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'h1, 8'h55}, "R6");
        rd(8'h10, "R6");
        // R7 turning edge clears remote-IRR; upper write on edge entry too
        wr(8'h00, 32'h16, "R7");
        wr(8'h10, lo_word(3, 1'b0, 1'b0), "R7");
        rd(8'h10, "R7");
        acc(1'b0, 8'h10, 32'h0, 1'b1, 0, 1'b1, 1'b0, "R9 edge set");
        wr(8'h00, 32'h11, "R7");
        wr(8'h10, 32'h9900_0000, "R7");
        rd_sel(8'h10, "R7");
        // R8 mask toggles on several pins
        for (int p = 4; p < 9; p++) begin
            wr(8'h00, 32'(16 + 2*p), "R8");
            wr(8'h10, lo_word(p, 1'b1, 1'b1), "R8");
            wr(8'h10, lo_word(p, 1'b1, 1'b1), "R8 repeat");
            wr(8'h10, lo_word(p, 1'b0, 1'b0), "R8");
        end
        // R9 write and update on the same entry in the same cycle
        wr(8'h00, 32'h1A, "R9");
        wr(8'h10, lo_word(5, 1'b0, 1'b1), "R9");
        acc(1'b1, 8'h10, lo_word(5, 1'b0, 1'b1), 1'b1, 5, 1'b1, 1'b0, "R9 same-cycle level");
        acc(1'b1, 8'h10, lo_word(5, 1'b1, 1'b0), 1'b1, 5, 1'b1, 1'b1, "R9 R7 same-cycle edge");
        rd(8'h10, "R9");
        acc(1'b1, 8'h10, lo_word(5, 1'b0, 1'b1), 1'b1, 6, 1'b1, 1'b1, "R9 two pins");
        rd(8'h10, "R9");
        rd_sel(8'h1C, "R9");
        // R11 other offsets
        wr(8'h20, 32'hFFFF_FFFF, "R11");
        wr(8'h04, 32'h0000_0033, "R11");
        wr(8'hFC, 32'h0000_0001, "R11");
        rd(8'h04, "R11");
        rd(8'h20, "R11");
        rd(8'hFC, "R11");
        rd(8'h00, "R11 select kept");
        rd(8'h10, "R11 window kept");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule